// File: doc/BRIEF.md
# Protected Page-Write Memory Controller

This block is the storage side of a 256-byte serial configuration memory. A separate bus front end decodes the serial protocol and drives the block with single-cycle strobes. The strobes open a command on the memory or on the protection register, load the byte address, present a write byte, fetch a read byte, or signal a stop. For every command opening, address byte and write byte the block returns a registered acknowledge or refusal. It also returns read data and a busy flag while the internal programming cycle runs.

Write bytes collect in a 16-entry page latch. Within a page, the low four address bits advance after each byte and wrap around. The latch goes into the array only when a stop arrives straight after an acknowledged data byte. That stop starts a programming cycle lasting `PROG_CYCLES` clocks.

A write to the protection register permanently locks the lower half of the array. Only the power-on input `por_n` clears this lock, which models a nonvolatile fuse. The ordinary reset `rst_n` leaves it untouched.

The controller is a single state machine:
- `ST_IDLE`: no command is open.
- `ST_MEM`: a memory command is open and nothing is pending.
- `ST_MDATA`: the last event was an acknowledged memory data byte.
- `ST_PREG`: a protection-register command is open.
- `ST_PDATA`: the last event was an acknowledged protection data byte.
- `ST_PROG`: the programming cycle is running.

Transitions:
- open-memory: any state except `ST_PROG` to `ST_MEM`.
- open-protect: to `ST_PREG`, or to `ST_IDLE` when the lock is already set.
- data-accept: `ST_MEM` or `ST_MDATA` to `ST_MDATA`, or `ST_PREG` or `ST_PDATA` to `ST_PDATA`.
- data-refuse: back to `ST_MEM` or `ST_PREG`.
- address-load: to `ST_MEM` or `ST_PREG`; this clears the latch.
- read: `ST_MEM` or `ST_MDATA` to `ST_MEM`.
- commit-stop: `ST_MDATA` or `ST_PDATA` to `ST_PROG`.
- abort-stop: any other open state to `ST_IDLE`; this discards the latch.
- expire: `ST_PROG` to `ST_IDLE`.

Top module: `spd_mem_ctrl`

## Requirements
- R1: Outside the programming cycle, an open-memory strobe is answered one cycle later with `resp_valid`=1 and `resp_ack`=1.
- R2: Each accepted write byte goes into the page latch at the current address. Then only address bits [3:0] increment, so writing three bytes from 1Eh fills 1Eh, 1Fh and 10h. Up to 16 bytes reach the array together on a commit-stop.
- R3: While `wr_allow`=0, every memory write byte is answered with `resp_ack`=0 and the array location keeps its value.
- R4: While the lock is set, write bytes to addresses 00h–7Fh get `resp_ack`=0 and are not stored. Addresses 80h–FFh stay writable.
- R5: A protection-register command sets `locked`=1 when it has an acknowledged data byte followed directly by a stop. The address and data values are ignored. `locked` then stays 1 through any number of `rst_n` pulses.
- R6: While `locked`=1, an open-protect strobe is answered with `resp_ack`=0.
- R7: A protection data byte sent with `wr_allow`=0 gets `resp_ack`=0, and a following stop leaves `locked`=0.
- R8: A stop that does not directly follow an acknowledged data byte (for example after an address byte or a refused byte) stores nothing and starts no programming cycle.
- R9: After a commit-stop, `busy` is 1 for exactly `PROG_CYCLES` cycles. During that time an open strobe is answered with `resp_ack`=0, and address and data strobes get no response.
- R10: A read strobe returns the array byte at the current address on `rd_data` one cycle later. It then increments the full 8-bit address, wrapping from FFh to 00h.
- R11: `por_n`=0 fills the array with FFh and clears the lock. `rst_n`=0 returns the state machine to idle with the address at 00h and `busy`=0, and keeps the array contents and the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| por_n | input | 1 | Synchronous active-low power-on clear of the array and the lock |
| wr_allow | input | 1 | 1 enables writes; 0 refuses every write byte |
| start_stb | input | 1 | Opens a command |
| start_prot | input | 1 | With `start_stb`: 1 targets the protection register, 0 the memory |
| addr_stb | input | 1 | Address byte strobe |
| addr_in | input | 8 | Byte address loaded by `addr_stb` |
| wr_stb | input | 1 | Write byte strobe |
| wr_data | input | 8 | Write byte |
| rd_stb | input | 1 | Read byte strobe |
| stop_stb | input | 1 | Stop strobe |
| resp_valid | output | 1 | A response to the previous cycle's strobe is present |
| resp_ack | output | 1 | 1 = acknowledge, 0 = refusal |
| rd_data | output | 8 | Byte returned by the last read |
| busy | output | 1 | The programming cycle is running |
| locked | output | 1 | The lower half is permanently write protected |

## Verification
The page function is exercised in several ways:
- A three-byte burst crossing the top of a page separates correct in-page wrap from a carry into the page bits.
- A byte refused because of `wr_allow`, and a write aborted by a new address before the stop, together separate a commit that needs a directly preceding acknowledge from one that fires on any stop.
- Writes on both sides of 80h after locking show that protection depends on the address, not on a global disable.
- Reads across FFh show the 8-bit wrap, as opposed to the 4-bit wrap used for writes.
- Counting busy cycles, then pulsing `rst_n` and `por_n` separately, distinguishes the volatile state from the modelled nonvolatile state.

// File: rtl/spd_pkg.sv
`timescale 1ns/1ps
package spd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_MEM   = 3'd1,
        ST_MDATA = 3'd2,
        ST_PREG  = 3'd3,
        ST_PDATA = 3'd4,
        ST_PROG  = 3'd5
    } ctl_state_t;
endpackage

// File: rtl/spd_page_buf.sv
`timescale 1ns/1ps
module spd_page_buf #(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8,
    localparam int PAGE_LEN = 1 << PAGE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         load,
    input  logic [PAGE_W-1:0]            idx,
    input  logic [DATA_W-1:0]            din,
    output logic [PAGE_LEN*DATA_W-1:0]   slot_data,
    output logic [PAGE_LEN-1:0]          slot_vld
);
    for (genvar i = 0; i < PAGE_LEN; i++) begin : g_slot
        logic              v_q;
        logic [DATA_W-1:0] d_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= '0;
            end else if (clr) begin
                v_q <= 1'b0;
            end else if (load && idx == PAGE_W'(i)) begin
                v_q <= 1'b1;
                d_q <= din;
            end
        end
        assign slot_vld[i] = v_q;
        assign slot_data[i*DATA_W +: DATA_W] = d_q;
    end

    // R2: a loaded byte always leaves at least one valid slot
    a_r2_slot_filled: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (slot_vld != '0));
endmodule

// File: rtl/spd_lock_guard.sv
`timescale 1ns/1ps
module spd_lock_guard #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              set_lock,
    input  logic              wr_allow,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked,
    output logic              accept
);
    logic lock_q;

    always_ff @(posedge clk) begin
        if (!por_n)
            lock_q <= 1'b0;
        else if (set_lock)
            lock_q <= 1'b1;
    end

    assign locked = lock_q;
    assign accept = wr_allow && !(lock_q && !addr[ADDR_W-1]);

    // R5: only power-on clears the lock
    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!por_n)
        lock_q |=> lock_q);
endmodule

// File: rtl/spd_prog_timer.sv
`timescale 1ns/1ps
module spd_prog_timer #(
    parameter int CYCLES = 20,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic start,
    output logic busy,
    output logic expire
);
    logic [CW-1:0] cnt_q;
    logic          busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (srst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(CYCLES - 1);
        end else if (expire) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy   = busy_q;
    assign expire = busy_q && (cnt_q == '0);

    // R9: busy cannot end while cycles remain
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n || srst)
        (busy_q && cnt_q != '0) |=> busy_q);
endmodule

// File: rtl/spd_mem_ctrl.sv
`timescale 1ns/1ps
module spd_mem_ctrl #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int PROG_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wr_allow,
    input  logic              start_stb,
    input  logic              start_prot,
    input  logic              addr_stb,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    input  logic              stop_stb,
    output logic              resp_valid,
    output logic              resp_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              locked
);
    import spd_pkg::*;

    localparam int DEPTH    = 1 << ADDR_W;
    localparam int PAGE_LEN = 1 << PAGE_W;

    ctl_state_t st_q, st_d;

    logic [ADDR_W-1:0]          addr_q;
    logic [DATA_W-1:0]          mem_q [DEPTH];
    logic [PAGE_LEN*DATA_W-1:0] slot_data;
    logic [PAGE_LEN-1:0]        slot_vld;
    logic                       resp_v_q, resp_a_q;
    logic [DATA_W-1:0]          rd_q;

    logic resp_v_d, resp_a_d;
    logic lat_clr, lat_wr, addr_ld, rd_do, commit, lock_set, tmr_start;
    logic accept, tmr_busy, tmr_expire;
    logic in_mem;

    assign in_mem = (st_q == ST_MEM) || (st_q == ST_MDATA);

    spd_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (lat_clr || !por_n),
        .load      (lat_wr),
        .idx       (addr_q[PAGE_W-1:0]),
        .din       (wr_data),
        .slot_data (slot_data),
        .slot_vld  (slot_vld)
    );

    spd_lock_guard #(.ADDR_W(ADDR_W)) u_guard (
        .clk      (clk),
        .por_n    (por_n),
        .set_lock (lock_set),
        .wr_allow (wr_allow),
        .addr     (addr_q),
        .locked   (locked),
        .accept   (accept)
    );

    spd_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .srst   (!por_n),
        .start  (tmr_start),
        .busy   (tmr_busy),
        .expire (tmr_expire)
    );

    // Next-state and strobe decode
    always_comb begin
        st_d      = st_q;
        resp_v_d  = 1'b0;
        resp_a_d  = 1'b0;
        lat_clr   = 1'b0;
        lat_wr    = 1'b0;
        addr_ld   = 1'b0;
        rd_do     = 1'b0;
        commit    = 1'b0;
        lock_set  = 1'b0;
        tmr_start = 1'b0;
        unique case (st_q)
            ST_PROG: begin
                if (start_stb)
                    resp_v_d = 1'b1;
                if (tmr_expire)
                    st_d = ST_IDLE;
            end
            default: begin
                if (start_stb) begin
                    resp_v_d = 1'b1;
                    lat_clr  = 1'b1;
                    if (!start_prot) begin
                        resp_a_d = 1'b1;
                        st_d     = ST_MEM;
                    end else if (!locked) begin
                        resp_a_d = 1'b1;
                        st_d     = ST_PREG;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end else if (stop_stb) begin
                    if (st_q == ST_MDATA) begin
                        commit    = 1'b1;
                        tmr_start = 1'b1;
                        st_d      = ST_PROG;
                    end else if (st_q == ST_PDATA) begin
                        lock_set  = 1'b1;
                        tmr_start = 1'b1;
                        st_d      = ST_PROG;
                    end else begin
                        lat_clr = 1'b1;
                        st_d    = ST_IDLE;
                    end
                end else if (addr_stb && st_q != ST_IDLE) begin
                    resp_v_d = 1'b1;
                    resp_a_d = 1'b1;
                    lat_clr  = 1'b1;
                    if (in_mem) begin
                        addr_ld = 1'b1;
                        st_d    = ST_MEM;
                    end else begin
                        st_d = ST_PREG;
                    end
                end else if (wr_stb && st_q != ST_IDLE) begin
                    resp_v_d = 1'b1;
                    if (in_mem) begin
                        if (accept) begin
                            resp_a_d = 1'b1;
                            lat_wr   = 1'b1;
                            st_d     = ST_MDATA;
                        end else begin
                            st_d = ST_MEM;
                        end
                    end else begin
                        if (wr_allow) begin
                            resp_a_d = 1'b1;
                            st_d     = ST_PDATA;
                        end else begin
                            st_d = ST_PREG;
                        end
                    end
                end else if (rd_stb && in_mem) begin
                    rd_do   = 1'b1;
                    lat_clr = 1'b1;
                    st_d    = ST_MEM;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else if (!por_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Outputs and address counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_v_q <= 1'b0;
            resp_a_q <= 1'b0;
            rd_q     <= '0;
            addr_q   <= '0;
        end else if (!por_n) begin
            resp_v_q <= 1'b0;
            resp_a_q <= 1'b0;
            rd_q     <= '0;
            addr_q   <= '0;
        end else begin
            resp_v_q <= resp_v_d;
            resp_a_q <= resp_a_d;
            if (addr_ld)
                addr_q <= addr_in;
            else if (lat_wr)
                addr_q <= {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
            else if (rd_do) begin
                rd_q   <= mem_q[addr_q];
                addr_q <= addr_q + ADDR_W'(1);
            end
        end
    end

    // Array: power-on erase, page commit
    always_ff @(posedge clk) begin
        if (!por_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= '1;
        end else if (commit) begin
            for (int i = 0; i < PAGE_LEN; i++)
                if (slot_vld[i])
                    mem_q[{addr_q[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= slot_data[i*DATA_W +: DATA_W];
        end
    end

    assign resp_valid = resp_v_q;
    assign resp_ack   = resp_a_q;
    assign rd_data    = rd_q;
    assign busy       = (st_q == ST_PROG);

    // R9: programming state and timer agree
    a_r9_timer_match: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        busy |-> tmr_busy);

    // R9: address and data strobes are silent while busy
    a_r9_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (busy && !start_stb && (addr_stb || wr_stb)) |=> !resp_valid);

    // R3: write disabled means refusal
    a_r3_refuse_disabled: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (!busy && wr_stb && !wr_allow && !start_stb && !stop_stb && !addr_stb) |=> !resp_ack);

    // R4: locked lower half refuses data
    a_r4_low_half: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (in_mem && wr_stb && locked && !addr_q[ADDR_W-1]
         && !start_stb && !stop_stb && !addr_stb) |=> (resp_valid && !resp_ack));

    // R6: locked device refuses protection commands
    a_r6_prot_refused: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (!busy && start_stb && start_prot && locked) |=> (resp_valid && !resp_ack));

    // R10: a read advances the full address
    a_r10_read_step: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (in_mem && rd_stb && !start_stb && !stop_stb && !addr_stb && !wr_stb)
        |=> (addr_q == $past(addr_q) + ADDR_W'(1)));
endmodule

// File: tb/spd_mem_ctrl_tb.sv
`timescale 1ns/1ps
module spd_mem_ctrl_tb;
    localparam int PROG = 20;
    localparam int WD_CYCLES = 100000;

    localparam logic [2:0] OP_NOP = 3'd0, OP_SM = 3'd1, OP_SP = 3'd2, OP_AD = 3'd3,
                           OP_WR = 3'd4, OP_RD = 3'd5, OP_ST = 3'd6, OP_WT = 3'd7;
    localparam logic [1:0] C_NO = 2'd0, C_ACK = 2'd1, C_RD = 2'd2, C_LK = 2'd3;

    // {op, arg, allow, check kind, expected, requirement number}
    localparam int NV = 60;
    localparam logic [25:0] VEC [NV] = '{
        // R1, R2: page burst wrapping inside page 1xh
        {OP_SM, 8'h00, 1'b1, C_ACK, 8'h01, 4'd1},
        {OP_AD, 8'h1E, 1'b1, C_ACK, 8'h01, 4'd2},
        {OP_WR, 8'hA1, 1'b1, C_ACK, 8'h01, 4'd2},
        {OP_WR, 8'hA2, 1'b1, C_ACK, 8'h01, 4'd2},
        {OP_WR, 8'hA3, 1'b1, C_ACK, 8'h01, 4'd2},
        {OP_ST, 8'h00, 1'b1, C_NO,  8'h00, 4'd2},
        {OP_WT, 8'h00, 1'b1, C_NO,  8'h00, 4'd2},
        {OP_SM, 8'h00, 1'b1, C_ACK, 8'h01, 4'd1},
        {OP_AD, 8'h1E, 1'b1, C_ACK, 8'h01, 4'd2},
        {OP_RD, 8'h00, 1'b1, C_RD,  8'hA1, 4'd2},
        {OP_RD, 8'h00, 1'b1, C_RD,  8'hA2, 4'd10},
        {OP_RD, 8'h00, 1'b1, C_RD,  8'hFF, 4'd11},
        {OP_AD, 8'h10, 1'b1, C_ACK, 8'h01, 4'd2},
        {OP_RD, 8'h00, 1'b1, C_RD,  8'hA3, 4'd2},
        {OP_ST, 8'h00, 1'b1, C_NO,  8'h00, 4'd2},
        // R3: writes disabled; stop after refusal (R8)
        {OP_SM, 8'h00, 1'b0, C_ACK, 8'h01, 4'd1},
        {OP_AD, 8'h40, 1'b0, C_ACK, 8'h01, 4'd3},
        {OP_WR, 8'h55, 1'b0, C_ACK, 8'h00, 4'd3},
        {OP_ST, 8'h00, 1'b0, C_NO,  8'h00, 4'd8},
        {OP_SM, 8'h00, 1'b1, C_ACK, 8'h01, 4'd8},
        {OP_AD, 8'h40, 1'b1, C_ACK, 8'h01, 4'd3},
        {OP_RD, 8'h00, 1'b1, C_RD,  8'hFF, 4'd3},
        {OP_ST, 8'h00, 1'b1, C_NO,  8'h00, 4'd3},
        // R8: a new address between data and stop drops the write
        {OP_SM, 8'h00, 1'b1, C_ACK, 8'h01, 4'd1},
        {OP_AD, 8'h50, 1'b1, C_ACK, 8'h01, 4'd8},
        {OP_WR, 8'h66, 1'b1, C_ACK, 8'h01, 4'd8},
        {OP_AD, 8'h50, 1'b1, C_ACK, 8'h01, 4'd8},
        {OP_ST, 8'h00, 1'b1, C_NO,  8'h00, 4'd8},
        {OP_SM, 8'h00, 1'b1, C_ACK, 8'h01, 4'd8},
        {OP_AD, 8'h50, 1'b1, C_ACK, 8'h01, 4'd8},
        {OP_RD, 8'h00, 1'b1, C_RD,  8'hFF, 4'd8},
        {OP_ST, 8'h00, 1'b1, C_NO,  8'h00, 4'd8},
        // R7: protection write with writes disabled
        {OP_SP, 8'h00, 1'b1, C_ACK, 8'h01, 4'd7},
        {OP_AD, 8'h00, 1'b1, C_ACK, 8'h01, 4'd7},
        {OP_WR, 8'h00, 1'b0, C_ACK, 8'h00, 4'd7},
        {OP_ST, 8'h00, 1'b0, C_NO,  8'h00, 4'd7},
        {OP_NOP, 8'h00, 1'b1, C_LK, 8'h00, 4'd7},
        // R5: protection write sets the lock
        {OP_SP, 8'h00, 1'b1, C_ACK, 8'h01, 4'd5},
        {OP_AD, 8'h3C, 1'b1, C_ACK, 8'h01, 4'd5},
        {OP_WR, 8'h5A, 1'b1, C_ACK, 8'h01, 4'd5},
        {OP_ST, 8'h00, 1'b1, C_NO,  8'h00, 4'd5},
        {OP_WT, 8'h00, 1'b1, C_NO,  8'h00, 4'd5},
        {OP_NOP, 8'h00, 1'b1, C_LK, 8'h01, 4'd5},
        // R6
        {OP_SP, 8'h00, 1'b1, C_ACK, 8'h00, 4'd6},
        {OP_ST, 8'h00, 1'b1, C_NO,  8'h00, 4'd6},
        // R4: lower half refused, upper half writable
        {OP_SM, 8'h00, 1'b1, C_ACK, 8'h01, 4'd4},
        {OP_AD, 8'h05, 1'b1, C_ACK, 8'h01, 4'd4},
        {OP_WR, 8'h99, 1'b1, C_ACK, 8'h00, 4'd4},
        {OP_ST, 8'h00, 1'b1, C_NO,  8'h00, 4'd4},
        {OP_SM, 8'h00, 1'b1, C_ACK, 8'h01, 4'd4},
        {OP_AD, 8'h85, 1'b1, C_ACK, 8'h01, 4'd4},
        {OP_WR, 8'h9A, 1'b1, C_ACK, 8'h01, 4'd4},
        {OP_ST, 8'h00, 1'b1, C_NO,  8'h00, 4'd4},
        {OP_WT, 8'h00, 1'b1, C_NO,  8'h00, 4'd4},
        {OP_SM, 8'h00, 1'b1, C_ACK, 8'h01, 4'd4},
        {OP_AD, 8'h05, 1'b1, C_ACK, 8'h01, 4'd4},
        {OP_RD, 8'h00, 1'b1, C_RD,  8'hFF, 4'd4},
        {OP_AD, 8'h85, 1'b1, C_ACK, 8'h01, 4'd4},
        {OP_RD, 8'h00, 1'b1, C_RD,  8'h9A, 4'd4},
        {OP_ST, 8'h00, 1'b1, C_NO,  8'h00, 4'd4}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, por_n = 1'b0, wr_allow = 1'b1;
    logic       start_stb = 1'b0, start_prot = 1'b0, addr_stb = 1'b0;
    logic       wr_stb = 1'b0, rd_stb = 1'b0, stop_stb = 1'b0;
    logic [7:0] addr_in = '0, wr_data = '0;
    logic       resp_valid, resp_ack, busy, locked;
    logic [7:0] rd_data;

    int checks = 0, failures = 0, cyc = 0;

    always #4 clk = ~clk;

    spd_mem_ctrl #(.PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_allow(wr_allow),
        .start_stb(start_stb), .start_prot(start_prot), .addr_stb(addr_stb),
        .addr_in(addr_in), .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
        .stop_stb(stop_stb), .resp_valid(resp_valid), .resp_ack(resp_ack),
        .rd_data(rd_data), .busy(busy), .locked(locked)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_CYCLES) begin
            failures++;
            $display("FAIL R9 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge with outputs settled
    task automatic do_op(input logic [2:0] op, input logic [7:0] arg, input logic allow);
        wr_allow = allow;
        if (op == OP_WT) begin
            repeat (PROG + 2) @(negedge clk);
        end else begin
            start_stb  = (op == OP_SM) || (op == OP_SP);
            start_prot = (op == OP_SP);
            addr_stb   = (op == OP_AD);
            wr_stb     = (op == OP_WR);
            rd_stb     = (op == OP_RD);
            stop_stb   = (op == OP_ST);
            addr_in    = arg;
            wr_data    = arg;
            @(posedge clk);
            @(negedge clk);
            start_stb = 1'b0; start_prot = 1'b0; addr_stb = 1'b0;
            wr_stb = 1'b0; rd_stb = 1'b0; stop_stb = 1'b0;
        end
    endtask

    task automatic expect_ack(input logic exp, input string req);
        check(resp_valid && resp_ack == exp, req, {resp_valid, resp_ack}, {1'b1, exp});
    endtask

    task automatic expect_rd(input logic [7:0] exp, input string req);
        check(rd_data == exp, req, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        por_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(!busy && !locked && !resp_valid, "R11 reset outputs", {busy, locked, resp_valid}, 0);

        for (int k = 0; k < NV; k++) begin
            logic [25:0] v;
            string tag;
            v = VEC[k];
            tag = $sformatf("R%0d vec%0d", v[3:0], k);
            do_op(v[25:23], v[22:15], v[14]);
            case (v[13:12])
                C_ACK: expect_ack(v[4], tag);
                C_RD:  expect_rd(v[11:4], tag);
                C_LK:  check(locked == v[4], tag, locked, v[4]);
                default: ;
            endcase
        end

        // R9: busy span after a commit
        do_op(OP_SM, 8'h00, 1'b1); expect_ack(1'b1, "R1 open");
        do_op(OP_AD, 8'h90, 1'b1);
        do_op(OP_WR, 8'h11, 1'b1); expect_ack(1'b1, "R4 upper write");
        do_op(OP_ST, 8'h00, 1'b1);
        begin
            int n = 0;
            while (busy && n < 1000) begin
                n++;
                @(negedge clk);
            end
            check(n == PROG, "R9 busy cycles", n, PROG);
        end
        // R9: open refused while busy
        do_op(OP_SM, 8'h00, 1'b1);
        do_op(OP_AD, 8'h91, 1'b1);
        do_op(OP_WR, 8'h22, 1'b1);
        do_op(OP_ST, 8'h00, 1'b1);
        do_op(OP_SM, 8'h00, 1'b1); expect_ack(1'b0, "R9 open during busy");
        do_op(OP_WR, 8'h33, 1'b1);
        check(!resp_valid, "R9 data silent during busy", resp_valid, 0);
        do_op(OP_WT, 8'h00, 1'b1);
        do_op(OP_SM, 8'h00, 1'b1); expect_ack(1'b1, "R9 open after busy");
        do_op(OP_AD, 8'h91, 1'b1);
        do_op(OP_RD, 8'h00, 1'b1); expect_rd(8'h22, "R9 byte committed");
        do_op(OP_ST, 8'h00, 1'b1);

        // R11: rst_n keeps lock and array
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(locked && !busy, "R5 lock kept over rst_n", {locked, busy}, 2);
        do_op(OP_SM, 8'h00, 1'b1);
        do_op(OP_AD, 8'h85, 1'b1);
        do_op(OP_RD, 8'h00, 1'b1); expect_rd(8'h9A, "R11 array kept over rst_n");
        do_op(OP_ST, 8'h00, 1'b1);

        // R11: power-on clears lock and erases
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        check(!locked, "R11 lock cleared by por", locked, 0);
        do_op(OP_SM, 8'h00, 1'b1);
        do_op(OP_AD, 8'h85, 1'b1);
        do_op(OP_RD, 8'h00, 1'b1); expect_rd(8'hFF, "R11 array erased by por");
        do_op(OP_ST, 8'h00, 1'b1);

        // R10: read wraps FFh -> 00h
        do_op(OP_SM, 8'h00, 1'b1);
        do_op(OP_AD, 8'hFF, 1'b1);
        do_op(OP_WR, 8'h77, 1'b1); expect_ack(1'b1, "R10 write FF");
        do_op(OP_ST, 8'h00, 1'b1);
        do_op(OP_WT, 8'h00, 1'b1);
        do_op(OP_SM, 8'h00, 1'b1);
        do_op(OP_AD, 8'h00, 1'b1);
        do_op(OP_WR, 8'h12, 1'b1); expect_ack(1'b1, "R4 low half writable after por");
        do_op(OP_ST, 8'h00, 1'b1);
        do_op(OP_WT, 8'h00, 1'b1);
        do_op(OP_SM, 8'h00, 1'b1);
        do_op(OP_AD, 8'hFF, 1'b1);
        do_op(OP_RD, 8'h00, 1'b1); expect_rd(8'h77, "R10 read FF");
        do_op(OP_RD, 8'h00, 1'b1); expect_rd(8'h12, "R10 wrap to 00");
        do_op(OP_ST, 8'h00, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule